// File: doc/BRIEF.md
# USB IN Endpoint Transmit Packet Buffer

This block holds a single packet that software builds one byte at a time and hands to the USB protocol engine when the host asks for data. Software pushes bytes through a write strobe and then names the target endpoint. Naming the endpoint arms the packet. When an IN token arrives for that endpoint, the block streams the bytes out with a valid/ready handshake. It marks the final byte and presents the data toggle for that endpoint. It then waits for the host's acknowledgement.

The block keeps a stall flag and a data toggle for every endpoint. Tokens it cannot serve are answered with a NAK, and the NAKed endpoint is recorded in a mask that software reads and clears. An armed packet with no bytes goes out as a zero-length packet. If the acknowledgement does not arrive in time, the bytes stay in storage and the same packet is sent again on the next matching token. A SETUP token clears the stall flag of endpoint 0. Completion of an acknowledged packet raises an interrupt.

Top module: `usb_in_pktbuf`

## Requirements
- R1: After reset the status word reads 0x1000000: idle (bit 24) is 1, and the data-present flag, the NAK mask and the selected endpoint are 0. The interrupt, tx_valid, hs_nak and hs_stall are 0, and every toggle and stall flag is 0.
- R2: Bytes written with data_wr are sent in write order once an IN token matches the armed endpoint. The first byte appears on the cycle after the token. Each beat advances on tx_ready, and tx_last marks the final byte. tx_pid carries that endpoint's toggle (0 = DATA0, 1 = DATA1). Byte writes are taken only while no send or acknowledgement wait is in progress.
- R3: At most MAX_BYTES bytes are stored, and writes beyond that are dropped. A packet filled past capacity sends exactly MAX_BYTES bytes.
- R4: Arming with no bytes stored sends one beat with tx_valid, tx_last and tx_empty all 1.
- R5: An IN token for an endpoint that is not armed, or when nothing is armed, gets a one-cycle hs_nak on the next cycle and produces no tx_valid. It also sets the bit of that endpoint in the NAK mask, status[15:0].
- R6: An IN token for an endpoint whose stall flag is 1 gets a one-cycle hs_stall instead of data or a NAK, even when that endpoint is armed. stall_wr writes the stall flag of the selected endpoint, status[19:16].
- R7: A setup_tok pulse clears the stall flag of endpoint 0 only. Stall flags of other endpoints are left unchanged.
- R8: A status_rd pulse clears the NAK mask. A NAK that occurs in the same cycle as the read is kept in the mask.
- R9: A flush_wr pulse discards the stored packet and disarms the block. status[25] becomes 0, and a following IN token to the old endpoint is NAKed.
- R10: An ACK during the wait flips the endpoint's toggle (status[26]), empties the buffer, disarms the block, returns idle to 1 and raises irq. irq stays high until irq_clr.
- R11: If no ACK arrives within ACK_TIMEOUT cycles after the last beat, idle returns to 1 and the packet is kept with irq still 0. The next matching token sends the same bytes from the first one, with the same tx_pid.
- R12: pid_wr sets the toggle of the selected endpoint to pid_val, and the value is visible in status[26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr | input | 1 | Append data_byte to the packet |
| data_byte | input | 8 | Byte to append |
| ep_wr | input | 1 | Select ep_num and arm the packet |
| ep_num | input | 4 | Endpoint number to arm |
| stall_wr | input | 1 | Write stall flag of the selected endpoint |
| stall_val | input | 1 | Stall flag value |
| pid_wr | input | 1 | Write toggle of the selected endpoint |
| pid_val | input | 1 | Toggle value |
| flush_wr | input | 1 | Discard the packet |
| status_rd | input | 1 | Status read strobe, clears the NAK mask |
| irq_clr | input | 1 | Clear the interrupt |
| status | output | 27 | {toggle, have, idle, 4'b0, epno, nak_mask} |
| irq | output | 1 | Packet acknowledged |
| in_tok | input | 1 | IN token received |
| in_ep | input | 4 | Endpoint of the IN token |
| setup_tok | input | 1 | SETUP token received |
| host_ack | input | 1 | Host ACK handshake received |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_empty | output | 1 | Beat carries no byte (zero-length packet) |
| tx_pid | output | 1 | Data toggle of the packet |
| hs_nak | output | 1 | Answer the token with NAK |
| hs_stall | output | 1 | Answer the token with STALL |

## Verification
The hardest case to reach is a lost acknowledgement. In that case the packet must survive a whole timeout window and come out again from its first byte with an unchanged toggle. The stimulus streams a short packet and then holds host_ack low for longer than ACK_TIMEOUT cycles. It then issues a second matching token and compares the replay byte for byte before finally acknowledging it. The 512-byte capacity edge is reached by writing three bytes past the limit and streaming the whole packet. Stall precedence is reached by arming an endpoint and stalling it before the token arrives.

// File: rtl/usb_in_pktbuf.sv
module usb_in_pktbuf #(
  parameter int MAX_BYTES   = 512,
  parameter int EP_COUNT    = 16,
  parameter int ACK_TIMEOUT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_wr,
  input  logic [7:0]  data_byte,
  input  logic        ep_wr,
  input  logic [3:0]  ep_num,
  input  logic        stall_wr,
  input  logic        stall_val,
  input  logic        pid_wr,
  input  logic        pid_val,
  input  logic        flush_wr,
  input  logic        status_rd,
  input  logic        irq_clr,
  output logic [26:0] status,
  output logic        irq,
  input  logic        in_tok,
  input  logic [3:0]  in_ep,
  input  logic        setup_tok,
  input  logic        host_ack,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_empty,
  output logic        tx_pid,
  output logic        hs_nak,
  output logic        hs_stall
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int PW = $clog2(MAX_BYTES);
  localparam int TW = $clog2(ACK_TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;

  state_t              state;
  logic [7:0]          mem [MAX_BYTES];
  logic [CW-1:0]       count, rd_ptr;
  logic [TW-1:0]       timer;
  logic [3:0]          sel_ep;
  logic                armed;
  logic [EP_COUNT-1:0] stall, toggle, nak_mask, nak_set;
  logic                tok_take, stall_hit, ep_match, wr_take;

  assign tok_take  = in_tok && state == S_IDLE && !flush_wr;
  assign stall_hit = stall[in_ep];
  assign ep_match  = armed && in_ep == sel_ep;
  assign nak_set   = (tok_take && !stall_hit && !ep_match) ? (EP_COUNT'(1) << in_ep) : '0;
  assign wr_take   = data_wr && state == S_IDLE && !flush_wr && count < CW'(MAX_BYTES);

  assign tx_valid = state == S_SEND;
  assign tx_data  = mem[rd_ptr[PW-1:0]];
  assign tx_empty = tx_valid && count == '0;
  assign tx_last  = tx_valid && (count == '0 || rd_ptr == count - CW'(1));
  assign tx_pid   = toggle[sel_ep];
  assign status   = {toggle[sel_ep], count != '0, state == S_IDLE, 4'b0, sel_ep, 16'(nak_mask)};

  always_ff @(posedge clk)
    if (wr_take) mem[count[PW-1:0]] <= data_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      count    <= '0;
      rd_ptr   <= '0;
      timer    <= '0;
      sel_ep   <= '0;
      armed    <= 1'b0;
      stall    <= '0;
      toggle   <= '0;
      nak_mask <= '0;
      irq      <= 1'b0;
      hs_nak   <= 1'b0;
      hs_stall <= 1'b0;
    end else begin
      hs_nak   <= 1'b0;
      hs_stall <= 1'b0;
      nak_mask <= (status_rd ? '0 : nak_mask) | nak_set;
      if (irq_clr) irq <= 1'b0;
      if (stall_wr) stall[sel_ep] <= stall_val;
      if (setup_tok) stall[0] <= 1'b0;
      if (pid_wr) toggle[sel_ep] <= pid_val;
      if (flush_wr) begin
        count  <= '0;
        rd_ptr <= '0;
        armed  <= 1'b0;
        state  <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            if (wr_take) count <= count + CW'(1);
            if (ep_wr) begin
              sel_ep <= ep_num;
              armed  <= 1'b1;
            end
            if (tok_take) begin
              if (stall_hit) hs_stall <= 1'b1;
              else if (ep_match) begin
                state  <= S_SEND;
                rd_ptr <= '0;
              end else hs_nak <= 1'b1;
            end
          end
          S_SEND: if (tx_ready) begin
            if (tx_last) begin
              state <= S_WAIT;
              timer <= '0;
            end else rd_ptr <= rd_ptr + CW'(1);
          end
          S_WAIT: begin
            if (host_ack) begin
              toggle[sel_ep] <= ~toggle[sel_ep];
              count  <= '0;
              armed  <= 1'b0;
              state  <= S_IDLE;
              irq    <= 1'b1;
            end else if (timer == TW'(ACK_TIMEOUT - 1)) begin
              state  <= S_IDLE;
              rd_ptr <= '0;
            end else timer <= timer + TW'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_in_pktbuf_chk.sv
module usb_in_pktbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       flush_wr,
  input logic       hs_nak,
  input logic       hs_stall,
  input logic       irq,
  input logic       host_ack,
  input logic       stat_idle
);
  a_r5_nak_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_nak && hs_stall));

  a_r2_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r2_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush_wr) |=> (tx_valid && $stable(tx_data)));

  a_r10_irq_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(host_ack));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stat_idle |-> !tx_valid);

  a_r6_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    hs_stall |-> !tx_valid);
endmodule

bind usb_in_pktbuf usb_in_pktbuf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .flush_wr(flush_wr),
  .hs_nak(hs_nak), .hs_stall(hs_stall), .irq(irq), .host_ack(host_ack),
  .stat_idle(status[24])
);

// File: tb/usb_in_pktbuf_tb_top.sv
module usb_in_pktbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int VT [NV][3] = '{
    '{1, 8, 16}, '{2, 1, 200}, '{1, 0, 0}, '{5, 64, 3}, '{0, 3, 90}, '{1, 16, 250}
  };

  logic clk = 0, rst_n = 0;
  logic data_wr = 0, ep_wr = 0, stall_wr = 0, stall_val = 0, pid_wr = 0, pid_val = 0;
  logic flush_wr = 0, status_rd = 0, irq_clr = 0, in_tok = 0, setup_tok = 0, host_ack = 0;
  logic tx_ready = 1;
  logic [7:0] data_byte = 0;
  logic [3:0] ep_num = 0, in_ep = 0;
  logic [26:0] status;
  logic irq, tx_valid, tx_last, tx_empty, tx_pid, hs_nak, hs_stall;
  logic [7:0] tx_data;
  logic [15:0] exp_tog = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_pktbuf dut_i (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_byte(data_byte),
    .ep_wr(ep_wr), .ep_num(ep_num), .stall_wr(stall_wr), .stall_val(stall_val),
    .pid_wr(pid_wr), .pid_val(pid_val), .flush_wr(flush_wr), .status_rd(status_rd),
    .irq_clr(irq_clr), .status(status), .irq(irq), .in_tok(in_tok), .in_ep(in_ep),
    .setup_tok(setup_tok), .host_ack(host_ack), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_empty(tx_empty), .tx_pid(tx_pid),
    .hs_nak(hs_nak), .hs_stall(hs_stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wbytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      data_wr = 1; data_byte = 8'((seed + i) & 255);
      @(negedge clk);
    end
    data_wr = 0;
  endtask

  task automatic arm(input int ep);
    ep_wr = 1; ep_num = 4'(ep); @(negedge clk); ep_wr = 0;
  endtask

  task automatic token(input int ep);
    in_tok = 1; in_ep = 4'(ep); @(negedge clk); in_tok = 0;
  endtask

  task automatic pulse_ack();
    host_ack = 1; @(negedge clk); host_ack = 0;
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic pulse_flush();
    flush_wr = 1; @(negedge clk); flush_wr = 0;
  endtask

  task automatic set_stall(input bit v);
    stall_wr = 1; stall_val = v; @(negedge clk); stall_wr = 0;
  endtask

  task automatic pulse_setup();
    setup_tok = 1; @(negedge clk); setup_tok = 0;
  endtask

  task automatic read_status();
    status_rd = 1; @(negedge clk); status_rd = 0;
  endtask

  task automatic collect(input int n, input int seed, input bit pid);
    int beats;
    beats = (n == 0) ? 1 : n;
    for (int i = 0; i < beats; i++) begin
      chk("R2 tx_valid", tx_valid, 1);
      if (n > 0) chk("R2 tx_data", tx_data, (seed + i) & 255);
      chk("R2 tx_last", tx_last, i == beats - 1);
      chk("R4 tx_empty", tx_empty, n == 0);
      chk("R2 tx_pid", tx_pid, pid);
      @(negedge clk);
    end
    chk("R2 end of packet", tx_valid, 0);
  endtask

  task automatic ack_and_check(input int ep);
    pulse_ack();
    exp_tog[ep] = ~exp_tog[ep];
    chk("R10 irq", irq, 1);
    chk("R10 idle", status[24], 1);
    chk("R10 have", status[25], 0);
    chk("R10 toggle", status[26], exp_tog[ep]);
    pulse_irq_clr();
    chk("R10 irq cleared", irq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 27'h1000000);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 hs", {hs_nak, hs_stall}, 0);

    for (int v = 0; v < NV; v++) begin
      wbytes(VT[v][1], VT[v][2]);
      arm(VT[v][0]);
      chk("R2 have", status[25], VT[v][1] > 0);
      chk("R2 epno", status[19:16], VT[v][0]);
      chk("R12 toggle view", status[26], exp_tog[VT[v][0]]);
      token(VT[v][0]);
      chk("R5 no nak on match", {hs_nak, hs_stall}, 0);
      collect(VT[v][1], VT[v][2], exp_tog[VT[v][0]]);
      chk("R11 busy during wait", status[24], 0);
      ack_and_check(VT[v][0]);
    end

    // R5 NAK when nothing armed, then when another endpoint is armed
    read_status();
    token(7);
    chk("R5 hs_nak unarmed", hs_nak, 1);
    chk("R5 no data", tx_valid, 0);
    chk("R5 mask bit7", status[15:0], 16'h0080);
    wbytes(2, 5);
    arm(2);
    token(3);
    chk("R5 hs_nak other ep", hs_nak, 1);
    chk("R5 no data other ep", tx_valid, 0);
    chk("R5 mask bits", status[15:0], 16'h0088);
    // R8 clear on read, with NAK in the same cycle kept
    in_tok = 1; in_ep = 4; status_rd = 1;
    @(negedge clk);
    in_tok = 0; status_rd = 0;
    chk("R8 mask after read", status[15:0], 16'h0010);
    read_status();
    chk("R8 mask cleared", status[15:0], 16'h0000);
    // R9 flush discards
    pulse_flush();
    chk("R9 have", status[25], 0);
    token(2);
    chk("R9 nak after flush", hs_nak, 1);
    chk("R9 no data after flush", tx_valid, 0);
    read_status();

    // R6 stall beats armed match; R7 setup leaves ep3 stalled
    arm(3);
    set_stall(1);
    token(3);
    chk("R6 hs_stall", hs_stall, 1);
    chk("R6 no nak", hs_nak, 0);
    chk("R6 no data", tx_valid, 0);
    chk("R6 mask unchanged", status[15:0], 16'h0000);
    pulse_setup();
    token(3);
    chk("R7 ep3 still stalled", hs_stall, 1);
    set_stall(0);
    pulse_flush();
    // R7 setup clears ep0 stall
    arm(0);
    set_stall(1);
    token(0);
    chk("R6 ep0 stalled", hs_stall, 1);
    pulse_setup();
    token(0);
    chk("R7 ep0 unstalled", hs_stall, 0);
    collect(0, 0, exp_tog[0]);
    ack_and_check(0);

    // R3 overflow capped at 512 bytes
    wbytes(515, 0);
    arm(9);
    token(9);
    collect(512, 0, exp_tog[9]);
    ack_and_check(9);

    // R11 timeout replay
    wbytes(3, 40);
    arm(2);
    token(2);
    collect(3, 40, exp_tog[2]);
    repeat (40) @(negedge clk);
    chk("R11 idle after timeout", status[24], 1);
    chk("R11 packet kept", status[25], 1);
    chk("R11 no irq", irq, 0);
    token(2);
    chk("R11 no nak on replay", hs_nak, 0);
    collect(3, 40, exp_tog[2]);
    ack_and_check(2);

    // R12 pid write
    arm(2);
    pulse_flush();
    pid_wr = 1; pid_val = ~exp_tog[2]; @(negedge clk); pid_wr = 0;
    exp_tog[2] = ~exp_tog[2];
    chk("R12 toggle written", status[26], exp_tog[2]);
    wbytes(1, 119);
    arm(2);
    token(2);
    collect(1, 119, exp_tog[2]);
    ack_and_check(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule